// File: doc/BRIEF.md
# DMA Channel Status Tracker

This block keeps the live status of a single DMA channel that moves packet data between memory and a USB device endpoint. A control write arrives either from software or from a descriptor load. It carries an enable bit, a chain-to-next-descriptor bit and a byte budget. From then on the block follows byte strobes, arbiter grants, packet completion, device-ended transfers and the state of the channel FIFO. It folds all of this into one 32-bit status word that software reads.

A software disable does not stop the channel at once while a packet is in flight. The channel stays enabled until its FIFO has drained. The two end flags and the descriptor flag are sticky and clear on a status read. If a set event arrives in the same cycle as the read, the set wins. The active flag is not cleared when the buffer budget runs out. It stays set through the next descriptor load and clears only when the packet completes. When the enable flag drops and the stored chain bit is set, the block raises a one-cycle request for the next descriptor.

Top module: `dma_chan_status`

## Requirements
- R1: After reset, `status` is all zero and `next_dsc_req` is low.
- R2: A software control write (`sw_wr`) with `sw_enable`=1 sets bit 0 (enable) and loads `sw_count` into bits 31:16 (remaining bytes), both visible one cycle later.
- R3: A `byte_stb` while enable is set and no write is present decrements bits 31:16 by one. It never goes below zero. While enable is clear, `byte_stb` leaves the count unchanged.
- R4: A `byte_stb` that takes the count from 1 to 0 sets bit 3 (buffer end) and clears bit 0 in the next cycle.
- R5: A `dev_end` pulse while enabled, with no write in the same cycle, sets bit 2 (transfer end) and clears bits 0 and 1 in the next cycle.
- R6: A write with enable=0 while the channel is enabled, active and the FIFO is not empty keeps bit 0 set. Bit 0 and bit 1 clear in the cycle after `fifo_empty` is seen high.
- R7: A write with enable=0 when the channel is not active, or when the FIFO is empty, clears bit 0 in the next cycle.
- R8: `next_dsc_req` pulses for one cycle, in the same cycle that bit 0 first reads 0, when the chain bit of the most recent write is 1.
- R9: Bit 1 (active) sets one cycle after `pkt_req` and `pkt_gnt` are both high while enabled, and clears one cycle after `pkt_done`. A request without a grant has no effect.
- R10: Bit 1 stays set when the count reaches zero and through a following descriptor load. It clears only on `pkt_done`, `dev_end` or drain completion.
- R11: `stat_rd` clears bits 2, 3 and 4 in the next cycle and leaves bits 0, 1 and 31:16 unchanged.
- R12: When `stat_rd` and the set event of bit 2, 3 or 4 occur in the same cycle, that bit reads 1 afterwards.
- R13: `dsc_ld` applies `dsc_enable`, `dsc_chain` and `dsc_count` like a control write and sets bit 4 (descriptor loaded). When `sw_wr` and `dsc_ld` coincide, the software fields win, and bit 4 is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr | input | 1 | Software control write strobe |
| sw_enable | input | 1 | Enable bit of software write |
| sw_chain | input | 1 | Load-next-descriptor bit of software write |
| sw_count | input | 16 | Byte budget of software write |
| dsc_ld | input | 1 | Descriptor load event |
| dsc_enable | input | 1 | Enable bit from descriptor |
| dsc_chain | input | 1 | Load-next-descriptor bit from descriptor |
| dsc_count | input | 16 | Byte budget from descriptor |
| pkt_req | input | 1 | Channel requests to source a packet |
| pkt_gnt | input | 1 | Arbiter grant to this channel |
| pkt_done | input | 1 | Current packet transfer completed |
| byte_stb | input | 1 | One byte moved |
| dev_end | input | 1 | Device ended the transfer |
| fifo_empty | input | 1 | Channel FIFO is empty |
| stat_rd | input | 1 | Status register read strobe |
| status | output | 32 | Count in 31:16, descriptor 4, buffer end 3, transfer end 2, active 1, enable 0 |
| next_dsc_req | output | 1 | One-cycle request to load the next descriptor |

## Verification
Every internal register appears in the status word or in the descriptor request one cycle after the edge that updates it. A wrong enable state or drain state shows at bit 0 in the very next sample, and shows again through a missing or spurious `next_dsc_req`. A wrong count shows in bits 31:16 and, a few strobes later, as a buffer-end flag that comes early or late. The sequence deliberately lines up collisions: a read with a set, a write with an end event, and a software write with a descriptor load. An error in priority therefore appears as a single wrong bit at the next sample.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
   localparam int FLAG_W    = 5;
   localparam int B_ENABLE  = 0;
   localparam int B_ACTIVE  = 1;
   localparam int B_XFEREND = 2;
   localparam int B_BUFEND  = 3;
   localparam int B_DSCLD   = 4;

   localparam int STICKY_N  = 3;
   localparam int S_XFEREND = 0;
   localparam int S_BUFEND  = 1;
   localparam int S_DSCLD   = 2;

   typedef enum logic [1:0] {
      CH_OFF   = 2'd0,
      CH_RUN   = 2'd1,
      CH_DRAIN = 2'd2
   } ch_state_e;
endpackage

// File: rtl/dcs_byte_count.sv
module dcs_byte_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic [CNT_W-1:0] cnt,
   output logic             last_byte
);
   localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
   localparam logic [CNT_W-1:0] ZERO = '0;

   logic [CNT_W-1:0] cnt_q;
   logic             can_dec;

   assign can_dec   = dec && (cnt_q != ZERO);
   assign last_byte = dec && (cnt_q == ONE);
   assign cnt       = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= ZERO;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (can_dec) begin
         cnt_q <= cnt_q - ONE;
      end
   end

   a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load && cnt_q != ZERO) |=> (cnt_q == $past(cnt_q) - ONE));
   a_r3_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load && cnt_q == ZERO) |=> (cnt_q == ZERO));
   a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!dec && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/dcs_sticky.sv
module dcs_sticky #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic         rd_clr,
   output logic [N-1:0] q
);
   generate
      if (N < 1) begin : g_bad_n
         $error("dcs_sticky: N must be at least 1");
      end
      for (genvar i = 0; i < N; i++) begin : g_bit
         logic f_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               f_q <= 1'b0;
            end else if (set[i]) begin
               f_q <= 1'b1;
            end else if (rd_clr) begin
               f_q <= 1'b0;
            end
         end
         assign q[i] = f_q;

         a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> f_q);
         a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_clr && !set[i]) |=> !f_q);
      end
   endgenerate
endmodule

// File: rtl/dcs_chan_ctl.sv
module dcs_chan_ctl
   import dcs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  logic wr_en,
   input  logic wr_chain,
   input  logic last_byte,
   input  logic dev_end,
   input  logic fifo_empty,
   input  logic pkt_req,
   input  logic pkt_gnt,
   input  logic pkt_done,
   output logic en,
   output logic act,
   output logic next_dsc_req
);
   ch_state_e st_q, st_d;
   logic      act_q, act_d;
   logic      chain_q, chain_d;
   logic      req_q;
   logic      en_q, en_d;
   logic      drain_done;
   logic      act_set, act_clr;

   assign en_q       = (st_q != CH_OFF);
   assign drain_done = (st_q == CH_DRAIN) && fifo_empty && !wr;

   always_comb begin
      st_d = st_q;
      if (wr) begin
         if (wr_en) begin
            st_d = CH_RUN;
         end else if (en_q && act_q && !fifo_empty) begin
            st_d = CH_DRAIN;
         end else begin
            st_d = CH_OFF;
         end
      end else if (en_q && (last_byte || dev_end)) begin
         st_d = CH_OFF;
      end else if (drain_done) begin
         st_d = CH_OFF;
      end
   end

   assign en_d    = (st_d != CH_OFF);
   assign chain_d = wr ? wr_chain : chain_q;

   assign act_set = en_q && pkt_req && pkt_gnt && !act_q;
   assign act_clr = act_q && (pkt_done || dev_end || drain_done);

   always_comb begin
      act_d = act_q;
      if (act_clr) begin
         act_d = 1'b0;
      end else if (act_set) begin
         act_d = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= CH_OFF;
         act_q   <= 1'b0;
         chain_q <= 1'b0;
         req_q   <= 1'b0;
      end else begin
         st_q    <= st_d;
         act_q   <= act_d;
         chain_q <= chain_d;
         req_q   <= en_q && !en_d && chain_d;
      end
   end

   assign en           = en_q;
   assign act          = act_q;
   assign next_dsc_req = req_q;

   a_r6_hold_while_draining: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && act_q && wr && !wr_en && !fifo_empty) |=> en_q);
   a_r6_release_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
      drain_done |=> (!en_q && !act_q));
   a_r5_dev_end_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && dev_end && !wr) |=> (!en_q && !act_q));
   a_r4_budget_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (last_byte && !wr) |=> !en_q);
   a_r8_req_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |-> (!en_q && $past(en_q)));
   a_r9_grant_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && pkt_req && pkt_gnt && !act_q) |=> act_q);
   a_r10_keep_active: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && !pkt_done && !dev_end && !drain_done) |=> act_q);
endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status
   import dcs_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int STAT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_wr,
   input  logic              sw_enable,
   input  logic              sw_chain,
   input  logic [CNT_W-1:0]  sw_count,
   input  logic              dsc_ld,
   input  logic              dsc_enable,
   input  logic              dsc_chain,
   input  logic [CNT_W-1:0]  dsc_count,
   input  logic              pkt_req,
   input  logic              pkt_gnt,
   input  logic              pkt_done,
   input  logic              byte_stb,
   input  logic              dev_end,
   input  logic              fifo_empty,
   input  logic              stat_rd,
   output logic [STAT_W-1:0] status,
   output logic              next_dsc_req
);
   localparam int GAP_W = STAT_W - CNT_W - FLAG_W;

   generate
      if (CNT_W < 1 || GAP_W < 0) begin : g_bad_width
         $error("dma_chan_status: count and flags do not fit the status word");
      end
   endgenerate

   logic             wr, wr_en, wr_chain;
   logic [CNT_W-1:0] wr_count;
   logic [CNT_W-1:0] cnt;
   logic             last_byte, dec;
   logic             en, act;
   logic [STICKY_N-1:0] sticky_set, sticky_q;
   logic [FLAG_W-1:0]   flags;

   assign wr       = sw_wr || dsc_ld;
   assign wr_en    = sw_wr ? sw_enable : dsc_enable;
   assign wr_chain = sw_wr ? sw_chain  : dsc_chain;
   assign wr_count = sw_wr ? sw_count  : dsc_count;
   assign dec      = en && byte_stb && !wr;

   dcs_byte_count #(.CNT_W(CNT_W)) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (wr),
      .load_val  (wr_count),
      .dec       (dec),
      .cnt       (cnt),
      .last_byte (last_byte)
   );

   dcs_chan_ctl u_ctl (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr           (wr),
      .wr_en        (wr_en),
      .wr_chain     (wr_chain),
      .last_byte    (last_byte),
      .dev_end      (dev_end),
      .fifo_empty   (fifo_empty),
      .pkt_req      (pkt_req),
      .pkt_gnt      (pkt_gnt),
      .pkt_done     (pkt_done),
      .en           (en),
      .act          (act),
      .next_dsc_req (next_dsc_req)
   );

   assign sticky_set[S_XFEREND] = en && dev_end && !wr;
   assign sticky_set[S_BUFEND]  = last_byte;
   assign sticky_set[S_DSCLD]   = dsc_ld;

   dcs_sticky #(.N(STICKY_N)) u_sticky (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (sticky_set),
      .rd_clr (stat_rd),
      .q      (sticky_q)
   );

   always_comb begin
      flags            = '0;
      flags[B_ENABLE]  = en;
      flags[B_ACTIVE]  = act;
      flags[B_XFEREND] = sticky_q[S_XFEREND];
      flags[B_BUFEND]  = sticky_q[S_BUFEND];
      flags[B_DSCLD]   = sticky_q[S_DSCLD];
   end

   generate
      if (GAP_W > 0) begin : g_gap
         assign status = {cnt, {GAP_W{1'b0}}, flags};
      end else begin : g_nogap
         assign status = {cnt, flags};
      end
   endgenerate

   a_r13_dsc_flag: assert property (@(posedge clk) disable iff (!rst_n)
      dsc_ld |=> status[B_DSCLD]);
   a_r2_write_enables: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_wr && sw_enable) |=> (status[B_ENABLE] && status[STAT_W-1 -: CNT_W] == $past(sw_count)));
endmodule

// File: tb/sim_dma_chan_status.sv
module sim_dma_chan_status;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sw_wr = 0, sw_enable = 0, sw_chain = 0;
   logic [15:0] sw_count = '0;
   logic        dsc_ld = 0, dsc_enable = 0, dsc_chain = 0;
   logic [15:0] dsc_count = '0;
   logic        pkt_req = 0, pkt_gnt = 0, pkt_done = 0;
   logic        byte_stb = 0, dev_end = 0, fifo_empty = 1, stat_rd = 0;
   logic [31:0] status;
   logic        next_dsc_req;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   typedef struct {
      logic [31:0] st;
      logic        req;
      string       tag;
   } exp_t;
   exp_t sb[$];

   always #2 clk = ~clk;

   dma_chan_status u0 (
      .clk(clk), .rst_n(rst_n),
      .sw_wr(sw_wr), .sw_enable(sw_enable), .sw_chain(sw_chain), .sw_count(sw_count),
      .dsc_ld(dsc_ld), .dsc_enable(dsc_enable), .dsc_chain(dsc_chain), .dsc_count(dsc_count),
      .pkt_req(pkt_req), .pkt_gnt(pkt_gnt), .pkt_done(pkt_done),
      .byte_stb(byte_stb), .dev_end(dev_end), .fifo_empty(fifo_empty), .stat_rd(stat_rd),
      .status(status), .next_dsc_req(next_dsc_req)
   );

   function automatic logic [31:0] mk(int c, bit d, bit b, bit t, bit a, bit e);
      return {c[15:0], 11'b0, d, b, t, a, e};
   endfunction

   task automatic check(string tag, logic [31:0] act_st, logic [31:0] exp_st,
                        logic act_r, logic exp_r);
      total++;
      if (act_st !== exp_st) begin
         bad++;
         $display("FAIL %s status actual=%h expected=%h", tag, act_st, exp_st);
      end
      total++;
      if (act_r !== exp_r) begin
         bad++;
         $display("FAIL %s next_dsc_req actual=%b expected=%b", tag, act_r, exp_r);
      end
   endtask

   // driver: inputs already set after a falling edge; push expectation, advance a cycle
   task automatic tick(logic [31:0] st, logic req, string tag);
      exp_t e;
      e.st = st; e.req = req; e.tag = tag;
      sb.push_back(e);
      @(negedge clk);
      sw_wr = 0; dsc_ld = 0; pkt_req = 0; pkt_gnt = 0; pkt_done = 0;
      byte_stb = 0; dev_end = 0; stat_rd = 0; fifo_empty = 1;
   endtask

   // monitor
   always @(posedge clk) begin
      exp_t e;
      #1;
      if (sb.size() > 0) begin
         e = sb.pop_front();
         check(e.tag, status, e.st, next_dsc_req, e.req);
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset", status, 32'h0, next_dsc_req, 1'b0);
      rst_n = 1'b1;

      sw_wr = 1; sw_enable = 1; sw_chain = 0; sw_count = 3;
      tick(mk(3,0,0,0,0,1), 0, "R2 enable write");
      byte_stb = 1;
      tick(mk(2,0,0,0,0,1), 0, "R3 decrement");
      pkt_req = 1; pkt_gnt = 1;
      tick(mk(2,0,0,0,1,1), 0, "R9 grant sets active");
      byte_stb = 1;
      tick(mk(1,0,0,0,1,1), 0, "R3 decrement");
      byte_stb = 1;
      tick(mk(0,0,1,0,1,0), 0, "R4 budget out, R10 active kept");
      byte_stb = 1;
      tick(mk(0,0,1,0,1,0), 0, "R3 strobe ignored when disabled");
      dsc_ld = 1; dsc_enable = 1; dsc_chain = 1; dsc_count = 5;
      tick(mk(5,1,1,0,1,1), 0, "R13 descriptor load, R10 active through load");
      pkt_done = 1;
      tick(mk(5,1,1,0,0,1), 0, "R10 active clears on packet done");
      stat_rd = 1;
      tick(mk(5,0,0,0,0,1), 0, "R11 read clears sticky");
      pkt_req = 1; pkt_gnt = 1;
      tick(mk(5,0,0,0,1,1), 0, "R9 grant sets active");
      dev_end = 1;
      tick(mk(5,0,0,1,0,0), 1, "R5 device end, R8 chain request");
      tick(mk(5,0,0,1,0,0), 0, "R8 single pulse");
      stat_rd = 1; dsc_ld = 1; dsc_enable = 0; dsc_chain = 0; dsc_count = 7;
      tick(mk(7,1,0,0,0,0), 0, "R12 set beats read");
      stat_rd = 1;
      tick(mk(7,0,0,0,0,0), 0, "R11 read clears descriptor flag");

      sw_wr = 1; sw_enable = 1; sw_chain = 1; sw_count = 10;
      tick(mk(10,0,0,0,0,1), 0, "R2 enable write");
      pkt_req = 1; pkt_gnt = 1; fifo_empty = 0;
      tick(mk(10,0,0,0,1,1), 0, "R9 grant sets active");
      sw_wr = 1; sw_enable = 0; sw_chain = 1; sw_count = 10; fifo_empty = 0;
      tick(mk(10,0,0,0,1,1), 0, "R6 disable held while FIFO busy");
      byte_stb = 1; fifo_empty = 0;
      tick(mk(9,0,0,0,1,1), 0, "R6 still draining");
      fifo_empty = 1;
      tick(mk(9,0,0,0,0,0), 1, "R6 drained, R8 chain request");

      sw_wr = 1; sw_enable = 1; sw_chain = 0; sw_count = 2;
      tick(mk(2,0,0,0,0,1), 0, "R2 enable write");
      sw_wr = 1; sw_enable = 0; sw_chain = 0; sw_count = 2;
      tick(mk(2,0,0,0,0,0), 0, "R7 immediate disable");
      sw_wr = 1; sw_enable = 1; sw_chain = 0; sw_count = 1;
      tick(mk(1,0,0,0,0,1), 0, "R2 enable write");
      byte_stb = 1; stat_rd = 1;
      tick(mk(0,0,1,0,0,0), 0, "R12 buffer end beats read, R4");
      sw_wr = 1; sw_enable = 1; sw_chain = 0; sw_count = 4;
      dsc_ld = 1; dsc_enable = 0; dsc_chain = 1; dsc_count = 9;
      tick(mk(4,1,1,0,0,1), 0, "R13 software write wins");
      pkt_req = 1; pkt_gnt = 0;
      tick(mk(4,1,1,0,0,1), 0, "R9 request without grant ignored");
      dev_end = 1; stat_rd = 1;
      tick(mk(4,0,0,1,0,0), 0, "R12 transfer end beats read, R5");

      repeat (2) @(negedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule